// File: doc/BRIEF.md
# Receive Packet Length and Address Filter

This block takes the byte stream that arrives once a sync word has been found and turns it into packet writes toward a receive FIFO. A start strobe opens a packet. The configured length mode then sets how many bytes belong to it. A length can come from a register, from the first received byte, or be open-ended until an external stop. The byte that carries the address can be checked against a device address, with the broadcast values 0x00 and 0xFF optionally accepted. A packet that fails the check produces no writes at all.

When a packet with a bounded length completes, the block can append two status bytes. The first holds the signal strength. The second holds the link quality together with the CRC result. The final written byte carries an end marker. A one-cycle done pulse reports each completed packet. A flush request can ask the FIFO to discard a packet whose CRC failed. Configuration is captured at the start strobe and stays fixed until the packet ends. CRC computation and FIFO storage live outside this block.

Top module: `rx_pkt_filter`

## Requirements
- R1: While reset is active and after it is released with no stimulus, wrValid, wrLast, pktDone and flushReq are all 0.
- R2: Length mode 0 (fixed) forwards exactly lenLimit bytes after the start strobe. Further bytes are ignored. When status append is off, wrLast is set on the last of these bytes only.
- R3: Length mode 1 (variable) consumes the first byte as the length L and does not write it. It then forwards the next L bytes.
- R4: In length mode 1, a length byte greater than lenLimit drops the packet. Nothing is written and no done pulse follows. The block then waits for a new start strobe, and the next valid packet is forwarded normally.
- R5: Address mode 0 accepts any address byte. Mode 1 accepts only devAddr. Mode 2 accepts devAddr or 0x00. Mode 3 accepts devAddr, 0x00 or 0xFF. The address byte is the first byte written for the packet.
- R6: A packet whose address byte is rejected writes no bytes and raises no done pulse.
- R7: With status append on, in length mode 0 or 1, two bytes follow the payload. The first is rssiVal. The second has bit 7 = crcOk and bits 6:0 = lqiVal. wrLast is set only on the second.
- R8: flushReq pulses together with pktDone when flushEn is set and crcOk is 0 at packet end. Otherwise it stays 0.
- R9: Length mode 2 (infinite) forwards every byte until a byte arrives with stopReq high. That byte is written with wrLast and pktDone in the same cycle. No status bytes and no flush request are produced.
- R10: Length mode 3 is reserved. A start strobe in that mode is ignored, and the bytes that follow are not written.
- R11: pktDone is a single-cycle pulse. It appears one cycle after the last payload byte's write when status append is off, and in the same cycle as the wrLast write otherwise.
- R12: A variable-mode packet with a length byte of 0 writes no payload bytes but still completes. It produces its status bytes if enabled, and its done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sopStrobe | input | 1 | Start of packet, one cycle, after sync detection |
| inByte | input | 8 | Received byte |
| inValid | input | 1 | inByte is valid this cycle |
| stopReq | input | 1 | Ends an infinite-mode packet at the byte it accompanies |
| lenMode | input | 2 | 0 fixed, 1 variable, 2 infinite, 3 reserved |
| lenLimit | input | 8 | Fixed length, or maximum length in variable mode |
| addrMode | input | 2 | Address check mode 0..3 |
| devAddr | input | 8 | Device address |
| statusEn | input | 1 | Append two status bytes |
| flushEn | input | 1 | Request a flush when CRC fails |
| crcOk | input | 1 | CRC result, valid at packet end |
| rssiVal | input | 8 | Signal strength for the first status byte |
| lqiVal | input | 7 | Link quality for the second status byte |
| wrData | output | 8 | FIFO write data |
| wrValid | output | 1 | FIFO write strobe |
| wrLast | output | 1 | Marks the final byte written for a packet |
| pktDone | output | 1 | One-cycle pulse per completed packet |
| flushReq | output | 1 | One-cycle request to flush the packet just written |

## Verification
On every cycle, the assertions check the following. An end marker never appears without a write. A flush request only comes with a done pulse and never in infinite mode. The done pulse never lasts two cycles. The remaining-byte count never exceeds the latched limit. Oversize lengths, rejected addresses and the reserved mode all send the controller straight back to idle. Only the directed scenarios can show the byte content and order in the write stream. The same holds for the exact cycle of pktDone relative to the marked byte, the packing of crcOk and link quality in the status byte, and the recovery after a dropped packet.

// File: rtl/rxpf_pkg.sv
package rxpf_pkg;

  localparam logic [1:0] LM_FIXED = 2'd0;
  localparam logic [1:0] LM_VAR   = 2'd1;
  localparam logic [1:0] LM_INF   = 2'd2;
  localparam logic [1:0] LM_RSVD  = 2'd3;

  localparam logic [1:0] AC_NONE  = 2'd0;
  localparam logic [1:0] AC_OWN   = 2'd1;
  localparam logic [1:0] AC_ZERO  = 2'd2;
  localparam logic [1:0] AC_BOTH  = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_LEN, S_ADDR, S_BODY, S_FIN, S_STAT
  } rxState_e;

  typedef struct packed {
    logic latchCfg;
    logic loadFixed;
    logic loadLen;
    logic dec;
    logic emitIn;
    logic emitRssi;
    logic emitStat;
    logic markLast;
    logic done;
    logic flush;
  } ctrlStrobe_t;

endpackage

// File: rtl/rxpf_dpath.sv
module rxpf_dpath
  import rxpf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       st,
  input  logic [DATA_W-1:0] inByte,
  input  logic [1:0]        lenMode,
  input  logic [DATA_W-1:0] lenLimit,
  input  logic [1:0]        addrMode,
  input  logic [DATA_W-1:0] devAddr,
  input  logic              statusEn,
  input  logic              flushEn,
  input  logic              crcOk,
  input  logic [DATA_W-1:0] rssiVal,
  input  logic [DATA_W-2:0] lqiVal,
  output logic [1:0]        cfgMode,
  output logic              cfgAddrOn,
  output logic              cfgStatus,
  output logic              cfgFlush,
  output logic              liveLimitZero,
  output logic              remainOne,
  output logic              addrPass,
  output logic              lenTooBig,
  output logic              inZero,
  output logic [DATA_W-1:0] wrData,
  output logic              wrValid,
  output logic              wrLast,
  output logic              pktDone,
  output logic              flushReq
);

  localparam logic [DATA_W-1:0] BCAST_LO = '0;
  localparam logic [DATA_W-1:0] BCAST_HI = '1;
  localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);

  logic [1:0]        cfgAddrMode;
  logic [DATA_W-1:0] cfgLimit;
  logic [DATA_W-1:0] cfgDev;
  logic [DATA_W-1:0] remain;

  // configuration captured at the start strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgMode     <= LM_FIXED;
      cfgAddrMode <= AC_NONE;
      cfgLimit    <= '0;
      cfgDev      <= '0;
      cfgStatus   <= 1'b0;
      cfgFlush    <= 1'b0;
    end else if (st.latchCfg) begin
      cfgMode     <= lenMode;
      cfgAddrMode <= addrMode;
      cfgLimit    <= lenLimit;
      cfgDev      <= devAddr;
      cfgStatus   <= statusEn;
      cfgFlush    <= flushEn;
    end
  end

  // remaining payload byte counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain <= '0;
    end else if (st.latchCfg) begin
      remain <= st.loadFixed ? lenLimit : '0;
    end else if (st.loadLen) begin
      remain <= inByte;
    end else if (st.dec && remain != '0) begin
      remain <= remain - ONE;
    end
  end

  always_comb begin
    unique case (cfgAddrMode)
      AC_NONE: addrPass = 1'b1;
      AC_OWN:  addrPass = (inByte == cfgDev);
      AC_ZERO: addrPass = (inByte == cfgDev) || (inByte == BCAST_LO);
      default: addrPass = (inByte == cfgDev) || (inByte == BCAST_LO) || (inByte == BCAST_HI);
    endcase
  end

  assign cfgAddrOn     = (cfgAddrMode != AC_NONE);
  assign lenTooBig     = (inByte > cfgLimit);
  assign inZero        = (inByte == '0);
  assign remainOne     = (remain == ONE);
  assign liveLimitZero = (lenLimit == '0);

  // registered FIFO-side outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrData   <= '0;
      wrValid  <= 1'b0;
      wrLast   <= 1'b0;
      pktDone  <= 1'b0;
      flushReq <= 1'b0;
    end else begin
      wrValid  <= st.emitIn | st.emitRssi | st.emitStat;
      wrLast   <= st.markLast;
      pktDone  <= st.done;
      flushReq <= st.flush;
      if (st.emitIn)        wrData <= inByte;
      else if (st.emitRssi) wrData <= rssiVal;
      else if (st.emitStat) wrData <= {crcOk, lqiVal};
    end
  end

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    wrLast |-> wrValid); // R2
  AST_FLUSH_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> pktDone); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |=> !pktDone); // R11
  AST_REMAIN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode != LM_INF) |-> (remain <= cfgLimit)); // R3
  AST_INF_NO_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> (cfgMode != LM_INF)); // R9

endmodule

// File: rtl/rxpf_ctrl.sv
module rxpf_ctrl
  import rxpf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sopStrobe,
  input  logic        inValid,
  input  logic        stopReq,
  input  logic        crcOk,
  input  logic [1:0]  lenMode,
  input  logic [1:0]  addrMode,
  input  logic        liveLimitZero,
  input  logic [1:0]  cfgMode,
  input  logic        cfgAddrOn,
  input  logic        cfgStatus,
  input  logic        cfgFlush,
  input  logic        remainOne,
  input  logic        addrPass,
  input  logic        lenTooBig,
  input  logic        inZero,
  output ctrlStrobe_t st
);

  rxState_e state, nxt;
  logic     take;
  logic     cfgInf;

  assign cfgInf = (cfgMode == LM_INF);

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    st   = '0;
    nxt  = state;
    take = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (sopStrobe && lenMode != LM_RSVD) begin
          st.latchCfg = 1'b1;
          if (lenMode == LM_VAR) begin
            nxt = S_LEN;
          end else if (lenMode == LM_FIXED) begin
            st.loadFixed = 1'b1;
            nxt = liveLimitZero ? S_FIN : ((addrMode != AC_NONE) ? S_ADDR : S_BODY);
          end else begin
            nxt = (addrMode != AC_NONE) ? S_ADDR : S_BODY;
          end
        end
      end
      S_LEN: begin
        if (inValid) begin
          if (lenTooBig) begin
            nxt = S_IDLE;
          end else begin
            st.loadLen = 1'b1;
            nxt = inZero ? S_FIN : (cfgAddrOn ? S_ADDR : S_BODY);
          end
        end
      end
      S_ADDR: begin
        if (inValid) begin
          if (addrPass) take = 1'b1;
          else          nxt  = S_IDLE;
        end
      end
      S_BODY: begin
        if (inValid) take = 1'b1;
      end
      S_FIN: begin
        if (cfgStatus) begin
          st.emitRssi = 1'b1;
          nxt = S_STAT;
        end else begin
          st.done  = 1'b1;
          st.flush = cfgFlush && !crcOk;
          nxt = S_IDLE;
        end
      end
      S_STAT: begin
        st.emitStat = 1'b1;
        st.markLast = 1'b1;
        st.done     = 1'b1;
        st.flush    = cfgFlush && !crcOk;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase

    // one accepted payload byte
    if (take) begin
      st.emitIn = 1'b1;
      nxt = S_BODY;
      if (cfgInf) begin
        if (stopReq) begin
          st.markLast = 1'b1;
          st.done     = 1'b1;
          nxt = S_IDLE;
        end
      end else begin
        st.dec = 1'b1;
        if (remainOne) begin
          st.markLast = !cfgStatus;
          nxt = S_FIN;
        end
      end
    end
  end

  AST_STATUS_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FIN && cfgStatus) |=> (state == S_STAT)); // R7
  AST_OVERSIZE_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_LEN && inValid && lenTooBig) |=> (state == S_IDLE)); // R4
  AST_ADDR_FAIL_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ADDR && inValid && !addrPass) |=> (state == S_IDLE)); // R6
  AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && sopStrobe && lenMode == LM_RSVD) |=> (state == S_IDLE)); // R10

endmodule

// File: rtl/rx_pkt_filter.sv
module rx_pkt_filter
  import rxpf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sopStrobe,
  input  logic [DATA_W-1:0] inByte,
  input  logic              inValid,
  input  logic              stopReq,
  input  logic [1:0]        lenMode,
  input  logic [DATA_W-1:0] lenLimit,
  input  logic [1:0]        addrMode,
  input  logic [DATA_W-1:0] devAddr,
  input  logic              statusEn,
  input  logic              flushEn,
  input  logic              crcOk,
  input  logic [DATA_W-1:0] rssiVal,
  input  logic [DATA_W-2:0] lqiVal,
  output logic [DATA_W-1:0] wrData,
  output logic              wrValid,
  output logic              wrLast,
  output logic              pktDone,
  output logic              flushReq
);

  ctrlStrobe_t st;
  logic [1:0]  cfgMode;
  logic        cfgAddrOn, cfgStatus, cfgFlush;
  logic        liveLimitZero, remainOne, addrPass, lenTooBig, inZero;

  rxpf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sopStrobe(sopStrobe), .inValid(inValid),
    .stopReq(stopReq), .crcOk(crcOk), .lenMode(lenMode), .addrMode(addrMode),
    .liveLimitZero(liveLimitZero), .cfgMode(cfgMode), .cfgAddrOn(cfgAddrOn),
    .cfgStatus(cfgStatus), .cfgFlush(cfgFlush), .remainOne(remainOne),
    .addrPass(addrPass), .lenTooBig(lenTooBig), .inZero(inZero), .st(st)
  );

  rxpf_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .inByte(inByte), .lenMode(lenMode),
    .lenLimit(lenLimit), .addrMode(addrMode), .devAddr(devAddr),
    .statusEn(statusEn), .flushEn(flushEn), .crcOk(crcOk), .rssiVal(rssiVal),
    .lqiVal(lqiVal), .cfgMode(cfgMode), .cfgAddrOn(cfgAddrOn),
    .cfgStatus(cfgStatus), .cfgFlush(cfgFlush), .liveLimitZero(liveLimitZero),
    .remainOne(remainOne), .addrPass(addrPass), .lenTooBig(lenTooBig),
    .inZero(inZero), .wrData(wrData), .wrValid(wrValid), .wrLast(wrLast),
    .pktDone(pktDone), .flushReq(flushReq)
  );

endmodule

// File: tb/sim_rx_pkt_filter.sv
`timescale 1ns/1ps
module sim_rx_pkt_filter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sopStrobe = 1'b0;
  logic [7:0] inByte = '0;
  logic       inValid = 1'b0;
  logic       stopReq = 1'b0;
  logic [1:0] lenMode = '0;
  logic [7:0] lenLimit = '0;
  logic [1:0] addrMode = '0;
  logic [7:0] devAddr = '0;
  logic       statusEn = 1'b0;
  logic       flushEn = 1'b0;
  logic       crcOk = 1'b1;
  logic [7:0] rssiVal = 8'h9A;
  logic [6:0] lqiVal = 7'h25;
  logic [7:0] wrData;
  logic       wrValid, wrLast, pktDone, flushReq;

  rx_pkt_filter u0 (
    .clk(clk), .rstN(rstN), .sopStrobe(sopStrobe), .inByte(inByte),
    .inValid(inValid), .stopReq(stopReq), .lenMode(lenMode), .lenLimit(lenLimit),
    .addrMode(addrMode), .devAddr(devAddr), .statusEn(statusEn), .flushEn(flushEn),
    .crcOk(crcOk), .rssiVal(rssiVal), .lqiVal(lqiVal), .wrData(wrData),
    .wrValid(wrValid), .wrLast(wrLast), .pktDone(pktDone), .flushReq(flushReq)
  );

  always #4 clk = ~clk;

  int nChk = 0, nErr = 0;
  int cyc = 0;
  logic [7:0] capData [64];
  bit         capLast [64];
  int         capCyc  [64];
  int capN = 0, doneN = 0, flushN = 0, doneCyc = -1;
  logic [7:0] expData [64];
  bit finished = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (wrValid && capN < 64) begin
        capData[capN] = wrData; capLast[capN] = wrLast; capCyc[capN] = cyc; capN++;
      end
      if (pktDone) begin doneN++; doneCyc = cyc; end
      if (flushReq) flushN++;
    end
  end

  task automatic chkEq(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearCap();
    capN = 0; doneN = 0; flushN = 0; doneCyc = -1;
  endtask

  task automatic setCfg(input logic [1:0] lm, input logic [7:0] lim,
                        input logic [1:0] am, input logic [7:0] dev,
                        input logic se, input logic fe);
    lenMode = lm; lenLimit = lim; addrMode = am; devAddr = dev;
    statusEn = se; flushEn = fe;
  endtask

  task automatic sendStart();
    sopStrobe = 1'b1; @(negedge clk); sopStrobe = 1'b0;
  endtask

  task automatic putByte(input logic [7:0] b, input logic stop);
    inByte = b; inValid = 1'b1; stopReq = stop;
    @(negedge clk);
    inValid = 1'b0; stopReq = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // compare captured stream with expData[0..n-1], marker on last only
  task automatic checkStream(input string tag, input int n);
    chkEq({tag, " count"}, capN, n);
    for (int i = 0; i < n && i < capN; i++) begin
      chkEq({tag, " data"}, capData[i], expData[i]);
      chkEq({tag, " last"}, capLast[i], (i == n - 1) ? 1 : 0);
    end
  endtask

  task automatic testReset();
    chkEq("R1 wrValid in reset", wrValid, 0);
    chkEq("R1 pktDone in reset", pktDone, 0);
    rstN = 1'b1; idle(2);
    chkEq("R1 wrValid", wrValid, 0);
    chkEq("R1 wrLast", wrLast, 0);
    chkEq("R1 pktDone", pktDone, 0);
    chkEq("R1 flushReq", flushReq, 0);
  endtask

  task automatic testFixed();
    setCfg(2'd0, 8'd4, 2'd0, 8'h00, 1'b0, 1'b0);
    clearCap(); sendStart();
    for (int i = 0; i < 5; i++) putByte(8'hA1 + 8'(i), 1'b0);
    idle(6);
    for (int i = 0; i < 4; i++) expData[i] = 8'hA1 + 8'(i);
    checkStream("R2 fixed", 4);
    chkEq("R11 fixed done count", doneN, 1);
    chkEq("R11 done one cycle after last", doneCyc, capCyc[3] + 1);
  endtask

  task automatic testVariable();
    setCfg(2'd1, 8'd10, 2'd0, 8'h00, 1'b0, 1'b0);
    clearCap(); sendStart();
    putByte(8'd3, 1'b0);
    putByte(8'h11, 1'b0); putByte(8'h22, 1'b0); putByte(8'h33, 1'b0);
    idle(6);
    expData[0] = 8'h11; expData[1] = 8'h22; expData[2] = 8'h33;
    checkStream("R3 variable", 3);
    chkEq("R3 done count", doneN, 1);
  endtask

  task automatic testOversize();
    setCfg(2'd1, 8'd5, 2'd0, 8'h00, 1'b0, 1'b0);
    clearCap(); sendStart();
    putByte(8'd6, 1'b0);
    for (int i = 0; i < 6; i++) putByte(8'h40 + 8'(i), 1'b0);
    idle(6);
    chkEq("R4 oversize writes", capN, 0);
    chkEq("R4 oversize done", doneN, 0);
    clearCap(); sendStart();
    putByte(8'd2, 1'b0); putByte(8'h5A, 1'b0); putByte(8'h5B, 1'b0);
    idle(6);
    expData[0] = 8'h5A; expData[1] = 8'h5B;
    checkStream("R4 recovery", 2);
  endtask

  task automatic runAddr(input logic [1:0] am, input logic [7:0] addr, input bit pass);
    setCfg(2'd0, 8'd3, am, 8'h5C, 1'b0, 1'b0);
    clearCap(); sendStart();
    putByte(addr, 1'b0); putByte(8'h11, 1'b0); putByte(8'h22, 1'b0);
    idle(6);
    if (pass) begin
      expData[0] = addr; expData[1] = 8'h11; expData[2] = 8'h22;
      checkStream("R5 address accepted", 3);
      chkEq("R5 accepted done", doneN, 1);
    end else begin
      chkEq("R6 rejected writes", capN, 0);
      chkEq("R6 rejected done", doneN, 0);
    end
  endtask

  task automatic testAddress();
    runAddr(2'd0, 8'h33, 1'b1);
    runAddr(2'd1, 8'h5C, 1'b1);
    runAddr(2'd1, 8'h00, 1'b0);
    runAddr(2'd2, 8'h00, 1'b1);
    runAddr(2'd2, 8'hFF, 1'b0);
    runAddr(2'd3, 8'hFF, 1'b1);
    runAddr(2'd3, 8'h12, 1'b0);
  endtask

  task automatic runStatus(input logic crc);
    setCfg(2'd0, 8'd2, 2'd0, 8'h00, 1'b1, 1'b0);
    crcOk = crc;
    clearCap(); sendStart();
    putByte(8'hD0, 1'b0); putByte(8'hD1, 1'b0);
    idle(6);
    expData[0] = 8'hD0; expData[1] = 8'hD1; expData[2] = 8'h9A;
    expData[3] = {crc, 7'h25};
    checkStream("R7 status bytes", 4);
    chkEq("R11 done with last status byte", doneCyc, capCyc[3]);
    chkEq("R7 no flush when disabled", flushN, 0);
    crcOk = 1'b1;
  endtask

  task automatic runFlush(input logic fe, input logic crc, input int expFlush);
    setCfg(2'd0, 8'd2, 2'd0, 8'h00, 1'b0, fe);
    crcOk = crc;
    clearCap(); sendStart();
    putByte(8'h71, 1'b0); putByte(8'h72, 1'b0);
    idle(6);
    chkEq("R8 flush count", flushN, expFlush);
    chkEq("R8 done count", doneN, 1);
    crcOk = 1'b1;
  endtask

  task automatic testInfinite();
    setCfg(2'd2, 8'd1, 2'd0, 8'h00, 1'b1, 1'b1);
    crcOk = 1'b0;
    clearCap(); sendStart();
    for (int i = 0; i < 5; i++) putByte(8'hE0 + 8'(i), (i == 4) ? 1'b1 : 1'b0);
    putByte(8'hEE, 1'b0);
    idle(6);
    for (int i = 0; i < 5; i++) expData[i] = 8'hE0 + 8'(i);
    checkStream("R9 infinite", 5);
    chkEq("R9 done same cycle as last", doneCyc, capCyc[4]);
    chkEq("R9 no flush", flushN, 0);
    crcOk = 1'b1;
  endtask

  task automatic testReserved();
    setCfg(2'd3, 8'd2, 2'd0, 8'h00, 1'b1, 1'b0);
    clearCap(); sendStart();
    putByte(8'h01, 1'b0); putByte(8'h02, 1'b0); putByte(8'h03, 1'b0);
    idle(6);
    chkEq("R10 reserved writes", capN, 0);
    chkEq("R10 reserved done", doneN, 0);
  endtask

  task automatic testZeroLen();
    setCfg(2'd1, 8'd8, 2'd1, 8'h5C, 1'b1, 1'b0);
    clearCap(); sendStart();
    putByte(8'd0, 1'b0); putByte(8'h5C, 1'b0);
    idle(6);
    expData[0] = 8'h9A; expData[1] = {1'b1, 7'h25};
    checkStream("R12 zero length", 2);
    chkEq("R12 zero length done", doneN, 1);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nChk, nErr);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finishRun();
  end

  initial begin
    idle(3);
    testReset();
    testFixed();
    testVariable();
    testOversize();
    testAddress();
    runStatus(1'b1);
    runStatus(1'b0);
    runFlush(1'b1, 1'b0, 1);
    runFlush(1'b1, 1'b1, 0);
    runFlush(1'b0, 1'b0, 0);
    testInfinite();
    testReserved();
    testZeroLen();
    finishRun();
  end

endmodule